// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous-serial target that opens a small byte-wide register space to an external controller over four wires: serial clock, active-low select, controller-out data and target-out data. Every frame begins with a 16-bit header made of a direction flag, a 14-bit address sent low bit first, and one filler bit. A write frame then carries one data byte, also low bit first. A read frame is answered by the target with one byte on the return line, low bit first.

The three serial inputs are resynchronised into the system clock, and all decoding runs on that clock. Inside the block are a parameterised bank of read/write byte registers at the bottom of the address space and a fixed identification byte at its own address. The serial clock idles low. Data is captured on its rising edge and launched on its falling edge.

Top module: `spi_regport`

## Requirements
- R1: The first header bit selects the direction: 1 is a read and 0 is a write.
- R2: Header bits 2 to 15 carry the address. Bit 2 is address bit 0 and bit 15 is address bit 13.
- R3: Header bit 16 is a filler, and its value has no effect on the address, the direction or the data.
- R4: A write frame is 24 serial clocks, with data bit 0 sent first. The byte is stored in the addressed register once the 24th rising edge has been seen, and a later read returns it.
- R5: In a read frame, the return line carries data bit 0 after the falling edge that follows the 16th rising edge. The remaining bits follow one per falling edge, so the byte is valid at rising edges 17 to 24.
- R6: Raising select before all 24 bits of a write have arrived abandons the frame, and the register keeps its old value.
- R7: The identification address (default 0x3F00) reads as ID_VALUE (default 0x6B), whose upper five bits are 01101. Writes to that address have no effect.
- R8: The return line is high impedance while select is high.
- R9: An address that is neither a bank register nor the identification address reads 0x00, and writing to it leaves every register unchanged.
- R10: After reset, every bank register reads 0x00.
- R11: Serial clocks beyond the 24th in a write frame are ignored, so no second byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the controller, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from controller to target |
| spi_miso | output | 1 | Serial data from target to controller, high impedance when not selected |

## Verification
Two actions can meet on one system clock. The first is the write commit, taken on the 24th rising edge. The second is a rise of the select line that ends the frame. The bench drives frames cut off after every possible bit count, including 23 and exactly 24. It raises select right after the last edge, then reads the register back, which shows whether the commit happened. The read-data path is also stressed: write frames to a register are followed at once by read frames of that same register, and every return byte is compared with a bench model of the register bank.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } xfer_dir_e;

   // extra header bits around the address: direction flag and filler
   localparam int HDR_OVERHEAD = 2;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_regport_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_regport_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
   import spi_regport_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso_q,
   output logic              miso_oe
);

   localparam int HDR_LEN = ADDR_W + HDR_OVERHEAD;
   localparam int FRM_LEN = HDR_LEN + DATA_W;
   localparam int CNT_W   = $clog2(FRM_LEN + 1);

   localparam logic [CNT_W-1:0] C_DIR   = '0;
   localparam logic [CNT_W-1:0] C_ALAST = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] C_PAD   = CNT_W'(HDR_LEN - 1);
   localparam logic [CNT_W-1:0] C_DATA0 = CNT_W'(HDR_LEN);
   localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRM_LEN - 1);
   localparam logic [CNT_W-1:0] C_DONE  = CNT_W'(FRM_LEN);

   if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_par
      $error("spi_regport_frame: ADDR_W >= 1 and DATA_W >= 2 required");
   end

   logic              sclk_d;
   logic              rise, fall;
   logic [CNT_W-1:0]  cnt;
   xfer_dir_e         dir_q;
   logic [ADDR_W-1:0] addr_sr;
   logic [DATA_W-1:0] data_sr;
   logic [DATA_W-1:0] tx_sr;

   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         cnt     <= '0;
         dir_q   <= DIR_WRITE;
         addr_sr <= '0;
         data_sr <= '0;
         tx_sr   <= '0;
         miso_q  <= 1'b0;
         miso_oe <= 1'b0;
      end else begin
         sclk_d  <= sclk_s;
         miso_oe <= ~cs_n_s;
         if (cs_n_s) begin
            cnt    <= '0;
            miso_q <= 1'b0;
         end else begin
            if (rise && cnt < C_DONE) begin
               cnt <= cnt + 1'b1;
               if (cnt == C_DIR) begin
                  dir_q <= xfer_dir_e'(mosi_s);
               end else if (cnt <= C_ALAST) begin
                  addr_sr <= {mosi_s, addr_sr[ADDR_W-1:1]};
               end else if (cnt == C_PAD) begin
                  // filler bit: sampled value is dropped
                  if (dir_q == DIR_READ) tx_sr <= rd_data;
               end else begin
                  data_sr <= {mosi_s, data_sr[DATA_W-1:1]};
               end
            end
            if (fall && dir_q == DIR_READ && cnt >= C_DATA0 && cnt <= C_LAST) begin
               miso_q <= tx_sr[0];
               tx_sr  <= {1'b0, tx_sr[DATA_W-1:1]};
            end
         end
      end
   end

   assign addr    = addr_sr;
   assign wr_en   = rise && !cs_n_s && (cnt == C_LAST) && (dir_q == DIR_WRITE);
   assign wr_data = {mosi_s, data_sr[DATA_W-1:1]};

   AST_IDLE_RESETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (cnt == '0)) else $error("frame count not cleared"); // R6
   AST_MISO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !miso_oe) else $error("return line still driven"); // R8
   AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!wr_en && (cnt == C_DONE || cs_n_s))) else $error("double commit"); // R11
   AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_s && !fall) |=> $stable(miso_q)) else $error("return bit moved off falling edge"); // R5

endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs #(
   parameter int                ADDR_W    = 14,
   parameter int                DATA_W    = 8,
   parameter int                NUM_REGS  = 16,
   parameter logic [ADDR_W-1:0] ID_ADDR   = 14'h3F00,
   parameter logic [DATA_W-1:0] ID_VALUE  = 8'h6B,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int            IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam logic [ADDR_W:0] NREG = (ADDR_W + 1)'(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_depth
      $error("spi_regport_regs: NUM_REGS out of range");
   end
   if ({1'b0, ID_ADDR} < NREG) begin : g_id_overlap
      $error("spi_regport_regs: ID_ADDR overlaps the register bank");
   end
   if (DATA_W == 8 && ID_VALUE[7:3] != 5'b01101) begin : g_bad_id
      $error("spi_regport_regs: ID_VALUE upper bits must be 01101");
   end

   logic [DATA_W-1:0] mem [NUM_REGS];
   logic              hit_bank, hit_id;
   logic [IDX_W-1:0]  idx;

   assign hit_bank = ({1'b0, addr} < NREG);
   assign hit_id   = (addr == ID_ADDR);
   assign idx      = addr[IDX_W-1:0];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[r] <= RESET_VAL;
         else if (wr_en && hit_bank && idx == IDX_W'(r))
            mem[r] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (hit_id)        rd_data = ID_VALUE;
      else if (hit_bank) rd_data = mem[idx];
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_bank && !hit_id) |-> (rd_data == '0)) else $error("unmapped read nonzero"); // R9
   AST_ID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_id |-> (rd_data[DATA_W-1 -: 5] == 5'b01101)) else $error("id code wrong"); // R7
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_bank) |=> (mem[$past(idx)] == $past(wr_data))) else $error("write lost"); // R4

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
   parameter int                ADDR_W      = 14,
   parameter int                DATA_W      = 8,
   parameter int                NUM_REGS    = 16,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ID_ADDR     = 14'h3F00,
   parameter logic [DATA_W-1:0] ID_VALUE    = 8'h6B
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sclk,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);

   logic              sclk_s, cs_n_s, mosi_s;
   logic [ADDR_W-1:0] addr;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data, rd_data;
   logic              miso_q, miso_oe;

   spi_regport_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b010)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in({spi_sclk, spi_cs_n, spi_mosi}),
      .sync_out({sclk_s, cs_n_s, mosi_s})
   );

   spi_regport_frame #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (sclk_s),
      .cs_n_s (cs_n_s),
      .mosi_s (mosi_s),
      .rd_data(rd_data),
      .addr   (addr),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .miso_q (miso_q),
      .miso_oe(miso_oe)
   );

   spi_regport_regs #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .ID_ADDR (ID_ADDR),
      .ID_VALUE(ID_VALUE)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (addr),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .rd_data(rd_data)
   );

   assign spi_miso = miso_oe ? miso_q : 1'bz;

endmodule

// File: tb/tb_spi_regport.sv
`timescale 1ns/1ps
module tb_spi_regport;

   localparam int          NREGS  = 16;
   localparam logic [13:0] IDA    = 14'h3F00;
   localparam logic [7:0]  IDV    = 8'h6B;
   localparam int          HALF   = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   wire  miso;

   int vectors = 0;
   int errors  = 0;
   logic [7:0] model [NREGS];

   always #4 clk = ~clk;

   spi_regport dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk),
      .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
   );

   function automatic logic [7:0] exp_read(input logic [13:0] a);
      if (a == IDA) return IDV;
      if (a < NREGS) return model[a[3:0]];
      return 8'h00;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   // drives nbits of one frame; collects return bits 17..24
   task automatic xfer(input bit rd, input logic [13:0] a, input logic [7:0] d,
                       input bit pad, input int nbits, output logic [7:0] q);
      logic [23:0] bits;
      q = 'x;
      bits[0] = rd;
      for (int i = 0; i < 14; i++) bits[1+i] = a[i];
      bits[15] = pad;
      for (int i = 0; i < 8; i++) bits[16+i] = d[i];
      cs_n = 1'b0;
      #(HALF);
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 24) ? bits[i] : ~bits[i % 24];
         #(HALF);
         if (i >= 16 && i < 24) q[i-16] = miso;
         sclk = 1'b1;
         #(HALF);
         sclk = 1'b0;
      end
      #(HALF);
      cs_n = 1'b1;
      #(HALF * 2);
   endtask

   task automatic do_write(input logic [13:0] a, input logic [7:0] d, input int nbits);
      logic [7:0] q;
      xfer(1'b0, a, d, 1'($urandom), nbits, q);
      if (nbits >= 24 && a < NREGS) model[a[3:0]] = d;
   endtask

   task automatic do_read(input string req, input logic [13:0] a);
      logic [7:0] q;
      xfer(1'b1, a, 8'($urandom), 1'($urandom), 24, q);
      check(req, q, exp_read(a));
   endtask

   initial begin
      #(190000 * 8);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [7:0] q;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
      #40 rst_n = 1'b1;
      #40;
      // R8: idle line high impedance
      vectors++;
      if (miso !== 1'bz) begin errors++; $display("FAIL R8: got %b expected z", miso); end
      // R10: reset contents
      for (int i = 0; i < NREGS; i++) do_read("R10", 14'(i));
      // R7: identification register and ignored write
      do_read("R7", IDA);
      do_write(IDA, 8'h00, 24);
      do_read("R7", IDA);
      // R2/R4: distinct address bits, data low bit first
      do_write(14'd1, 8'h01, 24);
      do_write(14'd8, 8'h80, 24);
      do_read("R2", 14'd1);
      do_read("R4", 14'd8);
      // R9: high address bits set, mirrors of bank addresses
      do_write(14'h2001, 8'hFF, 24);
      do_read("R9", 14'h2001);
      do_read("R9", 14'd1);
      // R3: filler bit value has no effect
      xfer(1'b0, 14'd3, 8'hA5, 1'b1, 24, q); model[3] = 8'hA5;
      xfer(1'b1, 14'd3, 8'h00, 1'b1, 24, q); check("R3", q, 8'hA5);
      xfer(1'b1, 14'd3, 8'h00, 1'b0, 24, q); check("R3", q, 8'hA5);
      // R6: every truncation of a write frame, down to 23 bits
      for (int n = 1; n < 24; n++) begin
         do_write(14'd5, 8'($urandom), n);
         do_read("R6", 14'd5);
      end
      // R11: extra clocks beyond 24 do not store again
      do_write(14'd6, 8'h3C, 32);
      do_read("R11", 14'd6);
      // R1/R5: random mix of reads and writes
      for (int it = 0; it < 120; it++) begin
         int op;
         logic [13:0] a;
         op = int'($urandom % 8);
         a = (op == 7) ? 14'($urandom) : 14'($urandom % NREGS);
         if (op < 4) begin
            do_write(a, 8'($urandom), 24);
            do_read("R1", a);
         end else if (op < 6) begin
            do_read("R5", a);
         end else if (op == 6) begin
            do_write(a, 8'($urandom), 1 + int'($urandom % 23));
            do_read("R6", a);
         end else begin
            do_write(a, 8'($urandom), 24);
            do_read("R9", a);
         end
      end
      vectors++;
      if (miso !== 1'bz) begin errors++; $display("FAIL R8: got %b expected z", miso); end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule